// File: doc/BRIEF.md
# Scan-Accessed Debug Register File with Mailbox

This block is a small debug register file that a host reaches through one 38-bit data register of a boundary-scan port. The TAP state machine and instruction decode sit outside. They deliver three strobes, capture, shift and update, in the block's clock domain, with one serial bit per shifting cycle. Every frame carries a 32-bit data field, a 5-bit register address and a direction flag. A write frame stores its data field into the addressed register on update. A read frame samples the addressed register on update, and that value travels out in the data field of the frame that follows.

The file holds four registers. A debug control word drives a monitor-mode enable. A debug status word is supplied by the core. A communications control word reports a fixed hardware version and two mailbox flags. A communications data word is a one-word mailbox in each direction between the host and the core. On the core side, a strobed write posts an outbound word and a strobed read consumes the inbound word. Both mailbox flags are exposed as status. A host read of the data address pops the outbound word. A host finishes a read sequence by addressing the communications control word, which has no side effect when read.

Top module: `dbg_scan_regfile`

## Requirements
- R1: A synchronous active-high reset clears the debug control word, both mailbox flags, both mailbox words, the read holding word and the shift chain, so `tdo`, `monitor_en`, `core_in_pending` and `core_out_valid` are all 0.
- R2: A frame is shifted least significant bit first: data bits 0..31 first, then address bits 0..4, then the direction flag as the 38th bit. A flag of 1 writes the data field into the addressed register on the update strobe.
- R3: A flag of 0 samples the addressed register on the update strobe. The sampled value is shifted out as the first 32 bits of the next frame, not the current one.
- R4: The debug control word at address 0 is 6 bits wide and reads back zero-extended. Its bit 4 drives `monitor_en`, so writing it as 0 selects halting debug.
- R5: Address 1 reads the 5-bit `dbg_status` input, zero-extended. Writes to it have no effect.
- R6: Address 2 reads as {VERSION in bits 31:28, zeros, inbound-pending in bit 1, outbound-valid in bit 0}. Writes to it have no effect, and reading it changes no flag.
- R7: A host write to address 3 stores the word on `core_in_data` and sets `core_in_pending`. A `core_rd` strobe clears the flag. If both happen in the same cycle, the host write wins.
- R8: A `core_wr` strobe stores `core_wdata` as the outbound word and sets `core_out_valid`. A host read of address 3 returns that word and clears the flag. If both happen in the same cycle, the core write wins.
- R9: Any other address reads as zero, and writes to it change no register.
- R10: On the capture strobe, the chain loads the held read value into the data field and zeros into the address and flag positions, so the last 6 bits shifted out of every frame are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture strobe for the data register |
| shift_en | input | 1 | Shift strobe; one bit moves per cycle |
| upd_en | input | 1 | Update strobe that applies the frame |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| dbg_status | input | STAT_W | Debug status supplied by the core |
| dbg_ctrl | output | CTRL_W | Debug control word |
| monitor_en | output | 1 | Monitor-mode enable taken from the control word |
| core_wr | input | 1 | Core posts an outbound word |
| core_wdata | input | 32 | Outbound word from the core |
| core_rd | input | 1 | Core consumes the inbound word |
| core_in_data | output | 32 | Inbound word written by the host |
| core_in_pending | output | 1 | Inbound word not yet consumed |
| core_out_valid | output | 1 | Outbound word not yet read by the host |

## Verification
On every cycle, the assertions check the local mailbox rules: each flag follows its set and clear strobes with the stated priority. They also check that the holding word moves only on a read update, that the control word moves only on a write to its address, that a frame shifted in lands where the address decode expects it, and that a version read carries the parameter. Only the bench's scenarios can show the end-to-end frame behaviour. These scenarios cover the one-frame delay of read data, zero-extension of the narrow registers, reads of unmapped addresses, the pop of the outbound word, and the fact that polling the control word leaves the flags alone.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
   localparam int DATA_W  = 32;
   localparam int ADDR_W  = 5;
   localparam int FRAME_W = DATA_W + ADDR_W + 1;

   localparam logic [ADDR_W-1:0] ADR_CTRL  = 5'd0;
   localparam logic [ADDR_W-1:0] ADR_STAT  = 5'd1;
   localparam logic [ADDR_W-1:0] ADR_MBCTL = 5'd2;
   localparam logic [ADDR_W-1:0] ADR_MBDAT = 5'd3;

   localparam int VER_LSB = 28;
   localparam int IN_FLAG_BIT  = 1;
   localparam int OUT_FLAG_BIT = 0;

   // packed MSB-first: last bit shifted in is the direction flag
   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } frame_t;
endpackage

// File: rtl/dbg_shift_chain.sv
module dbg_shift_chain #(
   parameter int FRAME_W = 38,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cap_en,
   input  logic               shift_en,
   input  logic               tdi,
   input  logic [DATA_W-1:0]  cap_data,
   output logic               tdo,
   output logic [FRAME_W-1:0] frame
);
   localparam int PAD_W = FRAME_W - DATA_W;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("frame must be wider than its data field");
      end
   endgenerate

   logic [FRAME_W-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst)           sr <= '0;
      else if (cap_en)   sr <= {{PAD_W{1'b0}}, cap_data};
      else if (shift_en) sr <= {tdi, sr[FRAME_W-1:1]};
   end

   assign tdo   = sr[0];
   assign frame = sr;

   assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
      (shift_en && !cap_en) |=> (sr[FRAME_W-1] == $past(tdi)));

   assert_capture_pad_R10: assert property (@(posedge clk) disable iff (rst)
      cap_en |=> (sr[FRAME_W-1:DATA_W] == '0));
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         host_wr,
   input  logic [W-1:0] host_wdata,
   input  logic         host_pop,
   input  logic         core_wr,
   input  logic [W-1:0] core_wdata,
   input  logic         core_rd,
   output logic [W-1:0] in_word,
   output logic         in_pending,
   output logic [W-1:0] out_word,
   output logic         out_valid
);
   always_ff @(posedge clk) begin
      if (rst) begin
         in_word    <= '0;
         in_pending <= 1'b0;
      end else if (host_wr) begin
         in_word    <= host_wdata;
         in_pending <= 1'b1;
      end else if (core_rd) begin
         in_pending <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word  <= '0;
         out_valid <= 1'b0;
      end else if (core_wr) begin
         out_word  <= core_wdata;
         out_valid <= 1'b1;
      end else if (host_pop) begin
         out_valid <= 1'b0;
      end
   end

   assert_in_set_R7: assert property (@(posedge clk) disable iff (rst)
      host_wr |=> (in_pending && in_word == $past(host_wdata)));
   assert_in_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (core_rd && !host_wr) |=> !in_pending);
   assert_out_set_R8: assert property (@(posedge clk) disable iff (rst)
      core_wr |=> (out_valid && out_word == $past(core_wdata)));
   assert_out_pop_R8: assert property (@(posedge clk) disable iff (rst)
      (host_pop && !core_wr) |=> !out_valid);
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg #(
   parameter int W       = 6,
   parameter int MON_BIT = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q,
   output logic         monitor_en
);
   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("control width out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wdata;
   end

   generate
      if (MON_BIT < W) begin : g_mon
         assign monitor_en = q[MON_BIT];
      end else begin : g_no_mon
         assign monitor_en = 1'b0;
      end
   endgenerate

   assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !we |=> $stable(q));
endmodule

// File: rtl/dbg_scan_regfile.sv
module dbg_scan_regfile
   import dbg_chain_pkg::*;
#(
   parameter int          CTRL_W  = 6,
   parameter int          STAT_W  = 5,
   parameter int          MON_BIT = 4,
   parameter logic [3:0]  VERSION = 4'h6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap_en,
   input  logic              shift_en,
   input  logic              upd_en,
   input  logic              tdi,
   output logic              tdo,
   input  logic [STAT_W-1:0] dbg_status,
   output logic [CTRL_W-1:0] dbg_ctrl,
   output logic              monitor_en,
   input  logic              core_wr,
   input  logic [31:0]       core_wdata,
   input  logic              core_rd,
   output logic [31:0]       core_in_data,
   output logic              core_in_pending,
   output logic              core_out_valid
);
   generate
      if (STAT_W < 1 || STAT_W > DATA_W) begin : g_bad_stat
         $error("status width out of range");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_bits;
   frame_t             fr;
   logic [DATA_W-1:0]  hold_q;
   logic [DATA_W-1:0]  rd_val;
   logic [DATA_W-1:0]  out_word;
   logic               upd_wr, upd_rd;
   logic               ctrl_we, host_wr, host_pop;

   dbg_shift_chain #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_chain (
      .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
      .tdi(tdi), .cap_data(hold_q), .tdo(tdo), .frame(frame_bits));

   assign fr       = frame_t'(frame_bits);
   assign upd_wr   = upd_en &  fr.wr;
   assign upd_rd   = upd_en & ~fr.wr;
   assign ctrl_we  = upd_wr && (fr.addr == ADR_CTRL);
   assign host_wr  = upd_wr && (fr.addr == ADR_MBDAT);
   assign host_pop = upd_rd && (fr.addr == ADR_MBDAT);

   dbg_ctrl_reg #(.W(CTRL_W), .MON_BIT(MON_BIT)) u_ctrl (
      .clk(clk), .rst(rst), .we(ctrl_we), .wdata(fr.data[CTRL_W-1:0]),
      .q(dbg_ctrl), .monitor_en(monitor_en));

   dbg_mailbox #(.W(DATA_W)) u_mbox (
      .clk(clk), .rst(rst),
      .host_wr(host_wr), .host_wdata(fr.data), .host_pop(host_pop),
      .core_wr(core_wr), .core_wdata(core_wdata), .core_rd(core_rd),
      .in_word(core_in_data), .in_pending(core_in_pending),
      .out_word(out_word), .out_valid(core_out_valid));

   always_comb begin
      rd_val = '0;
      case (fr.addr)
         ADR_CTRL:  rd_val = DATA_W'(dbg_ctrl);
         ADR_STAT:  rd_val = DATA_W'(dbg_status);
         ADR_MBCTL: begin
            rd_val[DATA_W-1:VER_LSB] = VERSION;
            rd_val[IN_FLAG_BIT]      = core_in_pending;
            rd_val[OUT_FLAG_BIT]     = core_out_valid;
         end
         ADR_MBDAT: rd_val = out_word;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         hold_q <= '0;
      else if (upd_rd) hold_q <= rd_val;
   end

   assert_hold_only_on_read_R3: assert property (@(posedge clk) disable iff (rst)
      !upd_rd |=> $stable(hold_q));
   assert_version_field_R6: assert property (@(posedge clk) disable iff (rst)
      (upd_rd && fr.addr == ADR_MBCTL) |=> (hold_q[DATA_W-1:VER_LSB] == VERSION));
   assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cap_en, shift_en, upd_en}));
endmodule

// File: tb/dbg_scan_regfile_tb.sv
module dbg_scan_regfile_tb;
   localparam int         CLK_PERIOD = 10;
   localparam logic [3:0] VER = 4'h6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cap_en = 0, shift_en = 0, upd_en = 0, tdi = 0;
   logic tdo;
   logic [4:0]  dbg_status = '0;
   logic [5:0]  dbg_ctrl;
   logic        monitor_en;
   logic        core_wr = 0, core_rd = 0;
   logic [31:0] core_wdata = '0;
   logic [31:0] core_in_data;
   logic        core_in_pending, core_out_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [37:0] last_out;
   event        scan_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_scan_regfile #(.VERSION(VER)) u_dut (
      .clk(clk), .rst(rst), .cap_en(cap_en), .shift_en(shift_en),
      .upd_en(upd_en), .tdi(tdi), .tdo(tdo), .dbg_status(dbg_status),
      .dbg_ctrl(dbg_ctrl), .monitor_en(monitor_en), .core_wr(core_wr),
      .core_wdata(core_wdata), .core_rd(core_rd), .core_in_data(core_in_data),
      .core_in_pending(core_in_pending), .core_out_valid(core_out_valid));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one full frame: capture, 38 shifts, update
   task automatic scan(logic wr, logic [4:0] addr, logic [31:0] data);
      logic [37:0] fin;
      fin = {wr, addr, data};
      @(negedge clk);
      cap_en = 1;
      @(negedge clk);
      cap_en = 0;
      for (int i = 0; i < 38; i++) begin
         shift_en = 1;
         tdi = fin[i];
         last_out[i] = tdo;
         @(negedge clk);
      end
      shift_en = 0;
      -> scan_ev;
      upd_en = 1;
      @(negedge clk);
      upd_en = 0;
   endtask

   task automatic hwrite(logic [4:0] addr, logic [31:0] data);
      scan(1'b1, addr, data);
   endtask

   task automatic hread(logic [4:0] addr, logic [31:0] exp, string tag);
      scan(1'b0, addr, 32'h0);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor: compares the data field of each frame with what the previous read promised
   always @(scan_ev) begin
      check("R10 pad bits", {26'b0, last_out[37:32]}, 32'h0);
      if (exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, last_out[31:0], e);
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      check("R1 reset tdo", {31'b0, tdo}, 0);
      check("R1 reset monitor_en", {31'b0, monitor_en}, 0);
      check("R1 reset in_pending", {31'b0, core_in_pending}, 0);
      check("R1 reset out_valid", {31'b0, core_out_valid}, 0);
      check("R1 reset ctrl", {26'b0, dbg_ctrl}, 0);

      // R2 / R4: write control, zero-extended readback, monitor bit
      hwrite(5'd0, 32'hFFFF_FFFF);
      check("R4 monitor_en set", {31'b0, monitor_en}, 1);
      check("R2 ctrl written", {26'b0, dbg_ctrl}, 32'h3F);
      hread(5'd0, 32'h0000_003F, "R4 ctrl readback");
      hwrite(5'd0, 32'h0000_0005);
      check("R4 halting debug", {31'b0, monitor_en}, 0);
      hread(5'd0, 32'h0000_0005, "R4 ctrl readback 2");

      // R5: status input, writes ignored
      dbg_status = 5'h1A;
      hwrite(5'd1, 32'hFFFF_FFFF);
      hread(5'd1, 32'h0000_001A, "R5 status read");

      // R6: version and idle flags
      hread(5'd2, {VER, 28'h0}, "R6 idle comms ctrl");

      // R7: host to core
      hwrite(5'd3, 32'hCAFE_F00D);
      check("R7 in_data", core_in_data, 32'hCAFE_F00D);
      check("R7 in_pending set", {31'b0, core_in_pending}, 1);
      hread(5'd2, {VER, 28'h2}, "R7 pending flag seen");
      @(negedge clk); core_rd = 1; @(negedge clk); core_rd = 0;
      check("R7 in_pending cleared", {31'b0, core_in_pending}, 0);

      // R8: core to host with pop
      @(negedge clk); core_wdata = 32'h1234_5678; core_wr = 1;
      @(negedge clk); core_wr = 0;
      check("R8 out_valid set", {31'b0, core_out_valid}, 1);
      hread(5'd2, {VER, 28'h1}, "R6 poll keeps flag");
      hread(5'd2, {VER, 28'h1}, "R6 second poll keeps flag");
      hread(5'd3, 32'h1234_5678, "R8 outbound word");
      hread(5'd2, {VER, 28'h0}, "R8 flag popped");
      check("R8 out_valid cleared", {31'b0, core_out_valid}, 0);

      // R6: writes to comms ctrl ignored
      hwrite(5'd2, 32'h0000_0003);
      hread(5'd2, {VER, 28'h0}, "R6 write ignored");

      // R9: unmapped
      hwrite(5'd9, 32'hDEAD_BEEF);
      check("R9 ctrl untouched", {26'b0, dbg_ctrl}, 32'h5);
      hread(5'd9, 32'h0, "R9 unmapped reads zero");
      hread(5'd31, 32'h0, "R9 unmapped 31 reads zero");

      // R3: a read's value is not in its own frame; the write frame below carries it
      hread(5'd0, 32'h5, "R3 delayed by one frame");
      hwrite(5'd30, 32'h0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule